// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block sits between the decoded write strobes of a byte-wide non-volatile memory model and its write sequencer. It watches each strobed address/data pair and keeps a protection flag that behaves like a non-volatile bit: reset leaves it alone, and only two fixed command sequences change it. A three-write lock sequence sets the flag and opens one page-load window. A six-write release sequence clears the flag.

For every strobe the block tells the sequencer in the same cycle whether the write was consumed as a command step (`cmd_hit`), whether it may be programmed (`wr_allow`), and whether it broke a sequence in progress (`seq_err`). While protection is set, a write is granted only inside the window that follows a lock sequence. That window closes when the sequencer reports that programming is finished. Command writes are never passed on as data.

Top module: `wp_cmd_guard`

## Requirements
- R1: `prot_on` is 0 from the start of simulation. Asserting `rst_n` does not change it.
- R2: Three strobes in order set `prot_on` on the clock edge that ends the third strobe: data 0xAA to address 0x5555, then data 0x55 to address 0x2AAA, then data 0xA0 to address 0x5555. Each of these strobes raises `cmd_hit` with `wr_allow` low.
- R3: Command addresses are compared on `wr_addr[14:0]` only, so bits 16 and 15 have no effect on matching.
- R4: After the lock sequence, up to PAGE_BYTES strobes each get `wr_allow`, and further strobes are refused. Command patterns inside this window count as payload, with `cmd_hit` low.
- R5: A `prog_done` pulse closes the window and `prot_on` stays 1. The next plain write is refused.
- R6: While `prot_on` is 1 and no window is open, a plain write gets neither `wr_allow` nor `cmd_hit`.
- R7: While `prot_on` is 0, a plain write gets `wr_allow`.
- R8: Six strobes in order clear `prot_on` on the edge that ends the sixth strobe: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Each strobe raises `cmd_hit`.
- R9: A strobe that does not match the next step of a partly entered sequence raises `seq_err` in that cycle and returns tracking to idle. The strobe is then handled as a plain write under the current protection state.
- R10: Clock cycles without a strobe do not change the progress of a sequence.
- R11: `wr_allow`, `cmd_hit` and `seq_err` are only high in cycles with `wr_stb`, and `cmd_hit` and `wr_allow` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequence tracking |
| wr_stb | input | 1 | One-cycle pulse marking a decoded write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prog_done | input | 1 | Pulse from the sequencer when a programming cycle ends |
| prot_on | output | 1 | Protection flag, kept through reset |
| wr_allow | output | 1 | This strobe may be programmed |
| cmd_hit | output | 1 | This strobe was taken as a command step |
| seq_err | output | 1 | This strobe broke a sequence in progress |

## Verification
The bench first shows that a reset in the protected state leaves the flag set. A design that cleared the flag on reset would grant a write that should be refused. It breaks a lock sequence at its second step, in both protection states. A design that kept tracking after the bad step, or that dropped the offending write instead of treating it as plain, would give the wrong `wr_allow`. It spreads a sequence over idle gaps, sets the upper address bits on a command write, and fills the page window one byte past its limit. It also writes a full command pattern inside the window. Designs that timed out, compared the full address, left the counter unbounded or decoded commands during payload would fail those checks.

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int MATCH_W    = 15,
  parameter int PAGE_BYTES = 256,
  parameter logic [MATCH_W-1:0] ADDR_A = 15'h5555,
  parameter logic [MATCH_W-1:0] ADDR_B = 15'h2AAA,
  parameter logic [DATA_W-1:0]  KEY1   = 8'hAA,
  parameter logic [DATA_W-1:0]  KEY2   = 8'h55,
  parameter logic [DATA_W-1:0]  OP_LOCK = 8'hA0,
  parameter logic [DATA_W-1:0]  OP_PRE  = 8'h80,
  parameter logic [DATA_W-1:0]  OP_FREE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              prot_on,
  output logic              wr_allow,
  output logic              cmd_hit,
  output logic              seq_err
);
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAGE_BYTES);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_K1   = 3'd1;
  localparam logic [2:0] ST_K2   = 3'd2;
  localparam logic [2:0] ST_LOAD = 3'd3;
  localparam logic [2:0] ST_E1   = 3'd4;
  localparam logic [2:0] ST_E2   = 3'd5;
  localparam logic [2:0] ST_E3   = 3'd6;

  logic [2:0]       st, nxt;
  logic [CNT_W-1:0] cnt;
  logic             prot_q = 1'b0;
  logic             step_ok, in_seq, room, set_prot, clr_prot;

  wire unused_hi = ^wr_addr[ADDR_W-1:MATCH_W];
  wire at_a = wr_addr[MATCH_W-1:0] == ADDR_A;
  wire at_b = wr_addr[MATCH_W-1:0] == ADDR_B;

  always_comb begin
    step_ok = 1'b0;
    nxt     = st;
    case (st)
      ST_IDLE: if (at_a && wr_data == KEY1) begin step_ok = 1'b1; nxt = ST_K1; end
      ST_K1:   if (at_b && wr_data == KEY2) begin step_ok = 1'b1; nxt = ST_K2; end
      ST_K2: begin
        if (at_a && wr_data == OP_LOCK)     begin step_ok = 1'b1; nxt = ST_LOAD; end
        else if (at_a && wr_data == OP_PRE) begin step_ok = 1'b1; nxt = ST_E1; end
      end
      ST_E1:   if (at_a && wr_data == KEY1)    begin step_ok = 1'b1; nxt = ST_E2; end
      ST_E2:   if (at_b && wr_data == KEY2)    begin step_ok = 1'b1; nxt = ST_E3; end
      ST_E3:   if (at_a && wr_data == OP_FREE) begin step_ok = 1'b1; nxt = ST_IDLE; end
      default: ;
    endcase
    if (!step_ok && st != ST_LOAD) nxt = ST_IDLE;
  end

  assign in_seq   = st != ST_IDLE && st != ST_LOAD;
  assign room     = cnt < CNT_MAX;
  assign cmd_hit  = wr_stb && step_ok;
  assign seq_err  = wr_stb && !step_ok && in_seq;
  assign wr_allow = wr_stb && !step_ok && ((st == ST_LOAD) ? room : !prot_q);
  assign set_prot = cmd_hit && st == ST_K2 && wr_data == OP_LOCK;
  assign clr_prot = cmd_hit && st == ST_E3;
  assign prot_on  = prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          st <= ST_IDLE;
    else if (st == ST_LOAD && prog_done) st <= ST_IDLE;
    else if (wr_stb)                     st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (st != ST_LOAD)  cnt <= '0;
    else if (wr_allow)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (set_prot)      prot_q <= 1'b1;
    else if (clr_prot) prot_q <= 1'b0;
  end
endmodule

// File: rtl/wp_cmd_guard_chk.sv
module wp_cmd_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic              prot_on,
  input logic              wr_allow,
  input logic              cmd_hit,
  input logic              seq_err
);
  assert_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> !(wr_allow || cmd_hit || seq_err));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_allow && cmd_hit));

  assert_set_by_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> ($past(cmd_hit) && $past(wr_data) == 8'hA0));

  assert_clear_by_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> ($past(cmd_hit) && $past(wr_data) == 8'h20));

  assert_err_not_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !cmd_hit);
endmodule

bind wp_cmd_guard wp_cmd_guard_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_wp_cmd_guard.sv
module test_wp_cmd_guard;
  localparam int PB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_done = 1'b0;
  logic        prot_on, wr_allow, cmd_hit, seq_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  typedef struct {
    logic  a;
    logic  h;
    logic  e;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  wp_cmd_guard #(.PAGE_BYTES(PB)) i_wp_cmd_guard (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .prot_on(prot_on),
    .wr_allow(wr_allow), .cmd_hit(cmd_hit), .seq_err(seq_err)
  );

  task automatic wr(input logic [16:0] a, input logic [7:0] d,
                    input logic ea, input logic eh, input logic ee, input string tag);
    exp_t x;
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    x.a = ea; x.h = eh; x.e = ee; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  task automatic chk_prot(input logic exp, input string tag);
    @(negedge clk); #5;
    n_tests++;
    if (prot_on !== exp) begin
      n_fail++;
      $display("FAIL %s prot_on actual=%b expected=%b", tag, prot_on, exp);
    end
  endtask

  always begin
    @(negedge clk); #5;
    if (wr_stb) begin
      exp_t x;
      x = q.pop_front();
      n_tests++;
      if (wr_allow !== x.a || cmd_hit !== x.h || seq_err !== x.e) begin
        n_fail++;
        $display("FAIL %s allow/hit/err actual=%b%b%b expected=%b%b%b",
                 x.tag, wr_allow, cmd_hit, seq_err, x.a, x.h, x.e);
      end
    end else if (rst_n && (wr_allow || cmd_hit || seq_err)) begin
      n_tests++; n_fail++;
      $display("FAIL R11 idle-cycle outputs actual=%b%b%b expected=000",
               wr_allow, cmd_hit, seq_err);
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    chk_prot(1'b0, "R1 start state");
    rst_n = 1'b1;
    idle(1);
    chk_prot(1'b0, "R1 after reset");

    wr(17'h00100, 8'h3C, 1, 0, 0, "R7 plain write unprotected");

    // lock sequence, upper address bits set on first step
    wr(17'h1D555, 8'hAA, 0, 1, 0, "R3 lock step1 high bits");
    wr(17'h02AAA, 8'h55, 0, 1, 0, "R2 lock step2");
    wr(17'h05555, 8'hA0, 0, 1, 0, "R2 lock step3");
    chk_prot(1'b1, "R2 flag set");

    wr(17'h00200, 8'h01, 1, 0, 0, "R4 payload 1");
    wr(17'h05555, 8'hAA, 1, 0, 0, "R4 command pattern as payload");
    wr(17'h00202, 8'h03, 1, 0, 0, "R4 payload 3");
    wr(17'h00203, 8'h04, 1, 0, 0, "R4 payload 4");
    wr(17'h00204, 8'h05, 0, 0, 0, "R4 beyond page limit");
    done_pulse();
    chk_prot(1'b1, "R5 flag kept after load");
    wr(17'h00300, 8'h11, 0, 0, 0, "R5 window closed");
    wr(17'h00301, 8'h12, 0, 0, 0, "R6 plain write protected");

    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
    chk_prot(1'b1, "R1 reset keeps flag");
    wr(17'h00302, 8'h13, 0, 0, 0, "R1 still blocked after reset");

    wr(17'h05555, 8'hAA, 0, 1, 0, "R9 start");
    wr(17'h02AAA, 8'h12, 0, 0, 1, "R9 bad step protected");
    wr(17'h05555, 8'hA0, 0, 0, 0, "R9 tracking back to idle");

    wr(17'h05555, 8'hAA, 0, 1, 0, "R10 step1");
    idle(5);
    wr(17'h0AAAA, 8'h55, 0, 1, 0, "R10 step2 after gap");
    idle(3);
    wr(17'h05555, 8'hA0, 0, 1, 0, "R10 step3 after gap");
    wr(17'h00400, 8'h77, 1, 0, 0, "R10 payload after gapped lock");
    done_pulse();
    wr(17'h00401, 8'h78, 0, 0, 0, "R6 blocked after second load");

    wr(17'h05555, 8'hAA, 0, 1, 0, "R8 step1");
    wr(17'h02AAA, 8'h55, 0, 1, 0, "R8 step2");
    wr(17'h05555, 8'h80, 0, 1, 0, "R8 step3");
    wr(17'h05555, 8'hAA, 0, 1, 0, "R8 step4");
    wr(17'h02AAA, 8'h55, 0, 1, 0, "R8 step5");
    chk_prot(1'b1, "R8 flag held before last step");
    wr(17'h15555, 8'h20, 0, 1, 0, "R8 step6");
    chk_prot(1'b0, "R8 flag cleared");
    wr(17'h00500, 8'h99, 1, 0, 0, "R7 write after release");

    wr(17'h05555, 8'hAA, 0, 1, 0, "R9 start unprotected");
    wr(17'h02AAB, 8'h55, 1, 0, 1, "R9 bad step unprotected allowed");
    wr(17'h02AAA, 8'h55, 1, 0, 0, "R9 idle again, plain write");
    chk_prot(1'b0, "R9 flag unchanged");

    idle(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule